// File: doc/BRIEF.md
# Multiplexed VFD Scan Timing Generator

This block sequences the grid and segment drive of a multiplexed vacuum fluorescent display. A frame is a series of digit slots, one per grid line, and the number of slots is set by a two-bit duty selection (16, 12, 8 or 4 digits). Every slot is divided into 16 equal steps. The number of oscillator clocks in a step grows as the digit count falls, so the frame length stays close to 8 K clocks at every setting. The grid line of the current digit is driven for a programmable number of steps at the start of the slot. The segment pattern of that digit is shown in the same window.

Segment patterns come from an external display RAM with an asynchronous read port. The block asks for the next digit's word in the last cycle of each slot and latches it at the slot boundary, so the word is held for the whole slot. The RAM port has a fixed timing and is not a stream, so it has no valid/ready handshake and no back-pressure: the RAM must return `ram_data` in the same cycle as `ram_addr`. All control inputs are plain levels. A display-off input blanks both outputs at once and leaves the scan running. A change of the duty selection restarts the scan from the beginning.

Top module: `vfd_scan_gen`

## Requirements
- R1: While `rst_n` is low, `grid_o` and `seg_o` are all zero. Reset sets the scan to digit 0, step 0 with the 16-digit duty, and makes the first cycle after release a fetch cycle (see R10).
- R2: One step lasts 32, 44, 64 or 128 clocks for `duty_sel` 00, 01, 10 or 11. A slot is 16 steps, so in steady state successive `ram_rd` pulses are 16 steps apart.
- R3: The frame has 16, 12, 8 or 4 digit slots for `duty_sel` 00, 01, 10 or 11. Bit i of `grid_o` is the grid of digit i, and at most one bit is set. After the last digit the scan wraps to digit 0.
- R4: The grid of the current digit is driven while the step index (0..15) is below the window length chosen by `win_sel`. Codes 000 to 110 give 2, 4, 6, 8, 10, 12 and 14 steps, and code 111 gives 15 steps. A change of `win_sel` takes effect at once, without a restart.
- R5: While `disp_on` is 0, `grid_o` and `seg_o` are zero in the same cycle. Scan timing continues unaffected.
- R6: `seg_o` carries the latched word masked to 20 segments (bits 19..0) for duty 00, 24 for 01, and 28 for 10 and 11. Its window and blanking are the same as for `grid_o`.
- R7: The segment word is captured from `ram_data` at the edge that ends a `ram_rd` cycle and is held for the whole slot. Changes on `ram_data` at any other time have no effect on `seg_o`.
- R8: When `duty_sel` takes a value different from the one in use, the scan restarts at digit 0, step 0 at the next edge, and this takes priority over a slot boundary falling in the same cycle. Writing the value already in use has no effect.
- R9: In the last clock of every slot, `ram_rd` is 1 and `ram_addr` gives the next digit index, wrapping to 0 after the last digit. Otherwise, outside a fetch cycle, `ram_rd` is 0 and `ram_addr` gives the current digit.
- R10: The first cycle after reset release or a restart is a fetch cycle. In it `ram_rd` is 1, `ram_addr` is 0, and both outputs are blank. This cycle counts as clock 0 of digit 0's first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_sel | input | 2 | Digit count: 00=16, 01=12, 10=8, 11=4 |
| win_sel | input | 3 | Grid on-time code in steps of a sixteenth of a slot |
| disp_on | input | 1 | 1 shows the display, 0 blanks all outputs |
| ram_rd | output | 1 | Fetch strobe for the display RAM |
| ram_addr | output | 4 | Digit index to read |
| ram_data | input | 28 | Segment word returned for `ram_addr`, same cycle |
| grid_o | output | 16 | Grid drives, one bit per digit |
| seg_o | output | 28 | Segment drives for the current digit |

## Verification
Two functions can fall in the same cycle: the slot-boundary fetch of the next digit and a restart caused by a new duty selection. The bench changes `duty_sel` exactly in the last clock of a slot, when `ram_rd` already points to the next digit. It then checks that the following cycle is a blank fetch of digit 0 and that the new slot timing counts from that cycle. Display RAM contents are also changed in the middle of slots to show that the held word survives until the next boundary.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_16 = 2'd0,
    DUTY_12 = 2'd1,
    DUTY_8  = 2'd2,
    DUTY_4  = 2'd3
  } duty_e;

  // clocks per step, minus one
  function automatic int unsigned step_last(duty_e d);
    case (d)
      DUTY_16: return 31;
      DUTY_12: return 43;
      DUTY_8:  return 63;
      default: return 127;
    endcase
  endfunction

  // highest digit index of a frame
  function automatic int unsigned digit_last(duty_e d);
    case (d)
      DUTY_16: return 15;
      DUTY_12: return 11;
      DUTY_8:  return 7;
      default: return 3;
    endcase
  endfunction

  // segments used per digit
  function automatic int unsigned seg_count(duty_e d);
    case (d)
      DUTY_16: return 20;
      DUTY_12: return 24;
      default: return 28;
    endcase
  endfunction

  // grid on-time in steps
  function automatic int unsigned win_steps(logic [2:0] code);
    if (code == 3'b111) return 15;
    return 2 * (int'(code) + 1);
  endfunction

endpackage

// File: rtl/vfd_step_timer.sv
module vfd_step_timer #(
  parameter int PRE_W  = 7,
  parameter int STEP_W = 4,
  parameter int DIG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PRE_W-1:0]  pre_last,
  input  logic [DIG_W-1:0]  dig_last,
  output logic [STEP_W-1:0] step,
  output logic [DIG_W-1:0]  digit,
  output logic [DIG_W-1:0]  next_digit,
  output logic              slot_end
);
  localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

  logic [PRE_W-1:0] pre;
  logic             step_end;

  assign step_end   = (pre == pre_last);
  assign slot_end   = step_end && (step == STEP_MAX);
  assign next_digit = (digit == dig_last) ? '0 : DIG_W'(digit + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre   <= '0;
      step  <= '0;
      digit <= '0;
    end else begin
      pre <= step_end ? '0 : PRE_W'(pre + 1'b1);
      if (step_end) step <= STEP_W'(step + 1'b1);
      if (slot_end) digit <= next_digit;
    end
  end
endmodule

// File: rtl/vfd_seg_latch.sv
module vfd_seg_latch #(
  parameter int SEG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] d,
  output logic [SEG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/vfd_out_gate.sv
module vfd_out_gate #(
  parameter int SEG_W   = 28,
  parameter int MAX_DIG = 16,
  parameter int DIG_W   = 4,
  parameter int STEP_W  = 4,
  parameter int CNT_W   = 5
) (
  input  logic               enable,
  input  logic [STEP_W-1:0]  step,
  input  logic [STEP_W:0]    win,
  input  logic [DIG_W-1:0]   digit,
  input  logic [SEG_W-1:0]   seg_in,
  input  logic [CNT_W-1:0]   seg_cnt,
  output logic [MAX_DIG-1:0] grid,
  output logic [SEG_W-1:0]   seg
);
  logic active;
  assign active = enable && ({1'b0, step} < win);

  for (genvar g = 0; g < MAX_DIG; g++) begin : g_grid
    assign grid[g] = active && (digit == DIG_W'(g));
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    assign seg[s] = active && (CNT_W'(s) < seg_cnt) && seg_in[s];
  end
endmodule

// File: rtl/vfd_scan_gen.sv
module vfd_scan_gen
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W   = 28,
  parameter int MAX_DIG = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 duty_sel,
  input  logic [2:0]                 win_sel,
  input  logic                       disp_on,
  output logic                       ram_rd,
  output logic [$clog2(MAX_DIG)-1:0] ram_addr,
  input  logic [SEG_W-1:0]           ram_data,
  output logic [MAX_DIG-1:0]         grid_o,
  output logic [SEG_W-1:0]           seg_o
);
  localparam int DIG_W  = $clog2(MAX_DIG);
  localparam int STEP_W = 4;
  localparam int PRE_W  = 7;
  localparam int CNT_W  = $clog2(SEG_W + 1);

  duty_e             duty_q;
  logic              fetch_q;
  logic              restart;
  logic [STEP_W-1:0] step;
  logic [DIG_W-1:0]  digit, next_digit;
  logic              slot_end;
  logic [SEG_W-1:0]  held;

  assign restart = (duty_e'(duty_sel) != duty_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q  <= DUTY_16;
      fetch_q <= 1'b1;
    end else begin
      duty_q  <= duty_e'(duty_sel);
      fetch_q <= restart;
    end
  end

  vfd_step_timer #(.PRE_W(PRE_W), .STEP_W(STEP_W), .DIG_W(DIG_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .pre_last   (PRE_W'(step_last(duty_q))),
    .dig_last   (DIG_W'(digit_last(duty_q))),
    .step       (step),
    .digit      (digit),
    .next_digit (next_digit),
    .slot_end   (slot_end)
  );

  assign ram_rd   = fetch_q || slot_end;
  assign ram_addr = slot_end ? next_digit : digit;

  vfd_seg_latch #(.SEG_W(SEG_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ram_rd),
    .d     (ram_data),
    .q     (held)
  );

  vfd_out_gate #(
    .SEG_W(SEG_W), .MAX_DIG(MAX_DIG), .DIG_W(DIG_W),
    .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_gate (
    .enable  (rst_n && disp_on && !fetch_q),
    .step    (step),
    .win     ((STEP_W+1)'(win_steps(win_sel))),
    .digit   (digit),
    .seg_in  (held),
    .seg_cnt (CNT_W'(seg_count(duty_q))),
    .grid    (grid_o),
    .seg     (seg_o)
  );
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int SEG_W   = 28,
  parameter int MAX_DIG = 16,
  parameter int DIG_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         duty_sel,
  input logic               disp_on,
  input logic               ram_rd,
  input logic [DIG_W-1:0]   ram_addr,
  input logic [MAX_DIG-1:0] grid_o,
  input logic [SEG_W-1:0]   seg_o
);
  p_grid_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o));

  p_four_digits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sel == 2'b11 && $stable(duty_sel)) |-> (grid_o[MAX_DIG-1:4] == '0));

  p_off_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (grid_o == '0 && seg_o == '0));

  p_seg_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sel == 2'b00 && $stable(duty_sel)) |-> (seg_o[SEG_W-1:20] == '0));

  p_restart_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sel != $past(duty_sel)) |=> (ram_rd && ram_addr == '0 && grid_o == '0));
endmodule

bind vfd_scan_gen vfd_scan_chk #(
  .SEG_W(SEG_W), .MAX_DIG(MAX_DIG), .DIG_W(DIG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .duty_sel (duty_sel),
  .disp_on  (disp_on),
  .ram_rd   (ram_rd),
  .ram_addr (ram_addr),
  .grid_o   (grid_o),
  .seg_o    (seg_o)
);

// File: tb/test_vfd_scan_gen.sv
`timescale 1ns/1ps
module test_vfd_scan_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  duty_sel = 2'b00;
  logic [2:0]  win_sel = 3'b011;
  logic        disp_on = 1'b1;
  logic        ram_rd;
  logic [3:0]  ram_addr;
  logic [27:0] ram_data;
  logic [15:0] grid_o;
  logic [27:0] seg_o;

  int unsigned salt = 1;
  int unsigned slot_salt = 1;
  int t = 0;
  int last_rd = -1;
  bit restart_next = 0;
  bit done = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vfd_scan_gen i_vfd_scan_gen (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .win_sel(win_sel),
    .disp_on(disp_on), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .ram_data(ram_data), .grid_o(grid_o), .seg_o(seg_o)
  );

  function automatic logic [27:0] word(int unsigned s, int unsigned d);
    logic [31:0] x;
    x = (s * 32'd2654435761) ^ (d * 32'd40503 + 32'h5bd1e995);
    x = x ^ (x >> 13);
    x = x * 32'h27d4eb2d;
    return x[27:0] ^ 28'h8a00001;
  endfunction

  always_comb ram_data = word(salt, 32'(ram_addr));

  function automatic int step_len(logic [1:0] d);
    case (d) 2'b00: return 32; 2'b01: return 44; 2'b10: return 64; default: return 128; endcase
  endfunction
  function automatic int n_dig(logic [1:0] d);
    case (d) 2'b00: return 16; 2'b01: return 12; 2'b10: return 8; default: return 4; endcase
  endfunction
  function automatic int n_seg(logic [1:0] d);
    case (d) 2'b00: return 20; 2'b01: return 24; default: return 28; endcase
  endfunction
  function automatic int win_len(logic [2:0] c);
    return (c == 3'b111) ? 15 : 2 * (int'(c) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0d act=%0h exp=%0h", tag, t, act, exp);
    end
  endtask

  function automatic int cur_step();
    int sl = 16 * step_len(duty_sel);
    return (t % sl) / step_len(duty_sel);
  endfunction

  // advance one clock, update the timeline model, compare all outputs
  task automatic tick();
    int p, n, sl, dig, stp;
    bit act, last;
    logic [15:0] eg;
    logic [27:0] es, mask;
    logic [3:0] ea;
    string tg;
    @(posedge clk);
    @(negedge clk);
    t = restart_next ? 0 : t + 1;
    restart_next = 0;
    p = step_len(duty_sel); n = n_dig(duty_sel); sl = 16 * p;
    if (t % sl == 0) slot_salt = salt;
    dig = (t / sl) % n;
    stp = (t % sl) / p;
    last = (t % sl == sl - 1);
    act = disp_on && (t > 0) && (stp < win_len(win_sel));
    mask = (n_seg(duty_sel) >= 28) ? 28'hFFFFFFF : 28'((32'd1 << n_seg(duty_sel)) - 1);
    eg = act ? 16'(16'd1 << dig) : 16'd0;
    es = act ? (word(slot_salt, 32'(dig)) & mask) : 28'd0;
    ea = (t == 0) ? 4'd0 : last ? 4'((dig + 1) % n) : 4'(dig);
    tg = !disp_on ? "R5" : (t == 0) ? "R10" : "R4";
    chk(grid_o == eg, tg, 32'(grid_o), 32'(eg));
    tg = !disp_on ? "R5" : (t == 0) ? "R10" : "R7";
    chk(seg_o == es, tg, 32'(seg_o), 32'(es));
    tg = (t == 0) ? "R8" : (last && dig == n - 1) ? "R3" : "R9";
    chk(ram_rd == ((t == 0) || last), tg, 32'(ram_rd), 32'((t == 0) || last));
    chk(ram_addr == ea, tg, 32'(ram_addr), 32'(ea));
    if (t == 0) last_rd = -1;
    else if (ram_rd) begin
      if (last_rd >= 0) chk(t - last_rd == sl, "R2", 32'(t - last_rd), 32'(sl));
      last_rd = t;
    end
  endtask

  task automatic set_duty(input logic [1:0] d);
    if (d != duty_sel) restart_next = 1;
    duty_sel = d;
  endtask

  task automatic random_stim();
    if ($urandom % 300 == 0) win_sel = 3'($urandom);
    if ($urandom % 1500 == 0) disp_on = 1'b0;
    else if (!disp_on && $urandom % 150 == 0) disp_on = 1'b1;
    if (t > 0 && cur_step() == 8 && $urandom % 40 == 0) salt = $urandom;
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      tick();
      random_stim();
    end
  endtask

  task automatic wait_slot_last();
    int sl;
    do begin
      tick();
      sl = 16 * step_len(duty_sel);
    end while (t % sl != sl - 1);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    // R1: outputs blank during reset even with the display enabled
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(grid_o == 16'd0, "R1", 32'(grid_o), 0);
      chk(seg_o == 28'd0, "R1", 32'(seg_o), 0);
    end
    rst_n = 1'b1;
    t = 0; slot_salt = salt;
    // first cycle after release is the fetch cycle
    chk(ram_rd == 1'b1 && ram_addr == 4'd0, "R10", {ram_rd, 4'(ram_addr)}, 32'h10);
    chk(grid_o == 16'd0, "R10", 32'(grid_o), 0);

    // 16 digits, every window code in turn (R4)
    for (int c = 0; c < 8; c++) begin
      win_sel = 3'(c);
      for (int i = 0; i < 600; i++) tick();
    end
    run(9000);

    // same value again: no restart (R8)
    set_duty(2'b00);
    run(500);

    // remaining digit counts, plus random traffic
    for (int d = 1; d < 4; d++) begin
      set_duty(2'(d));
      run(10000);
    end

    // restart in the same cycle as a slot boundary (R8 with R9)
    disp_on = 1'b1;
    wait_slot_last();
    set_duty(2'b01);
    tick();
    chk(ram_addr == 4'd0 && ram_rd, "R8", 32'(ram_addr), 0);
    run(2000);
    wait_slot_last();
    set_duty(2'b10);
    run(3000);

    // display off across a slot boundary, then on again (R5)
    disp_on = 1'b0;
    for (int i = 0; i < 2100; i++) tick();
    disp_on = 1'b1;
    win_sel = 3'b111;
    for (int i = 0; i < 2100; i++) tick();

    // mid-slot RAM change must not reach the outputs (R7)
    set_duty(2'b00);
    for (int i = 0; i < 40; i++) tick();
    salt = salt + 7;
    for (int i = 0; i < 600; i++) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule